// File: doc/BRIEF.md
# Trigger Busy Generator

This block produces the BUSY level returned to a trigger system. Every level-0 trigger pulse starts a dwell timer whose length is a programmed number of coarse ticks. One tick is a fixed number of clock cycles, 400 by default, which is 10 µs at a 25 ns clock. BUSY is the OR of three sources: the running dwell timer, a flag saying downstream buffers are full, and a trigger receiver that is not ready. Because of this, BUSY stays high while the buffers are full even after the timer has run out.

A 16-bit condition word shows which sources are active at this moment. A saturating counter adds up the clock cycles during which BUSY was high. Software reads it as a low half and a high half. Reading the low half freezes a copy of the high half, so a low read followed by a high read gives a consistent pair. The dwell length is a writable register. Trigger decoding is not part of this block: the trigger pulse, the buffer-full flag and the ready flag arrive as plain inputs.

Top module: `trig_busy_gen`

## Requirements
- R1: After reset the dwell register holds 0x000A, the busy-time counter and its frozen high half are zero, and the timer is idle.
- R2: A trigger pulse sampled at a clock edge makes the timer source active from that edge on, for exactly dwell × TICK_CYCLES clock cycles (TICK_CYCLES defaults to 400).
- R3: A trigger that arrives while the timer is running restarts the dwell from the full programmed value.
- R4: A trigger taken while the dwell register is zero does not activate the timer source.
- R5: BUSY is high in every cycle in which `buf_full` is high, whatever the state of the timer, so BUSY cannot drop while the buffers are full.
- R6: BUSY is high in every cycle in which `rx_ready` is low, and condition bit 15 is set in those cycles.
- R7: The condition word has bit 0 = timer running, bit 1 = buffers full, bit 15 = receiver not ready. All other bits are zero. BUSY is the OR of these three flags.
- R8: The busy-time counter rises by one at each clock edge at which BUSY was high and holds otherwise. `busy_time_lo` always shows its low RD_W bits.
- R9: The busy-time counter stops at all ones instead of wrapping.
- R10: At each clock edge at which `cnt_rd_lo` is high, `busy_time_hi` captures the counter's upper bits (CNT_W−RD_W of them, zero-extended) as they stood in that cycle, and it holds them until the next such edge.
- R11: A write to the dwell register takes effect at the clock edge and is visible on `tmo_value`. A trigger sampled at the same edge still uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l0_trig | input | 1 | Level-0 trigger pulse, one cycle |
| buf_full | input | 1 | Downstream buffers full |
| rx_ready | input | 1 | Trigger receiver ready |
| tmo_we | input | 1 | Write strobe for the dwell register |
| tmo_wdata | input | TMO_W | New dwell length in ticks |
| tmo_value | output | TMO_W | Current dwell register |
| cnt_rd_lo | input | 1 | Low-half read strobe; freezes the high half |
| busy_out | output | 1 | BUSY toward the trigger system |
| busy_cond | output | 16 | Busy-source condition word |
| busy_time_lo | output | RD_W | Live low half of the busy-time counter |
| busy_time_hi | output | RD_W | High half frozen at the last low read |

## Verification
The bench applies four kinds of stimulus:
- An isolated trigger with the reset dwell value. Its measured BUSY length separates a correct tick count from an off-by-one in either the prescaler or the tick countdown.
- A second trigger placed halfway through a short dwell. It shows whether the timer reloads or simply lets the first dwell finish.
- A buffer-full flag held beyond the timer's expiry, and a stretch with the receiver not ready. These show that each source reaches BUSY and its own condition bit on its own.
- Low-half read strobes spread across the counter's run, followed by a long not-ready stretch that drives the counter to its limit. These tell a consistent frozen high half from a live one, and saturation from wrap-around.

// File: rtl/tbg_pkg.sv
`timescale 1ns/1ps
package tbg_pkg;
   localparam int COND_W        = 16;
   localparam int COND_TIMER_IX = 0;
   localparam int COND_FULL_IX  = 1;
   localparam int COND_NRDY_IX  = 15;

   typedef struct packed {
      logic nrdy;
      logic full;
      logic timer;
   } busy_src_t;
endpackage

// File: rtl/tbg_tick_timer.sv
`timescale 1ns/1ps
module tbg_tick_timer #(
   parameter int TICK_CYCLES = 400,
   parameter int TMO_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TMO_W-1:0] load_val,
   output logic             active
);
   localparam int PS_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

   logic [TMO_W-1:0] ticks_left;
   logic             tick_end;

   generate
      if (TICK_CYCLES == 1) begin : g_no_prescale
         assign tick_end = 1'b1;
      end else begin : g_prescale
         logic [PS_W-1:0] ps_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ps_cnt <= '0;
            end else if (start || ticks_left == '0) begin
               ps_cnt <= '0;
            end else if (ps_cnt == PS_W'(TICK_CYCLES - 1)) begin
               ps_cnt <= '0;
            end else begin
               ps_cnt <= ps_cnt + 1'b1;
            end
         end
         assign tick_end = (ps_cnt == PS_W'(TICK_CYCLES - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ticks_left <= '0;
      end else if (start) begin
         ticks_left <= load_val;
      end else if (ticks_left != '0 && tick_end) begin
         ticks_left <= ticks_left - 1'b1;
      end
   end

   assign active = (ticks_left != '0);
endmodule

// File: rtl/tbg_busy_cond.sv
`timescale 1ns/1ps
module tbg_busy_cond
   import tbg_pkg::*;
(
   input  logic              timer_active,
   input  logic              buf_full,
   input  logic              rx_ready,
   output logic              busy,
   output logic [COND_W-1:0] cond
);
   busy_src_t src;

   always_comb begin
      src.timer = timer_active;
      src.full  = buf_full;
      src.nrdy  = ~rx_ready;
   end

   always_comb begin
      cond                = '0;
      cond[COND_TIMER_IX] = src.timer;
      cond[COND_FULL_IX]  = src.full;
      cond[COND_NRDY_IX]  = src.nrdy;
   end

   assign busy = |src;
endmodule

// File: rtl/tbg_busy_meter.sv
`timescale 1ns/1ps
module tbg_busy_meter #(
   parameter int CNT_W    = 32,
   parameter int RD_W     = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rd_lo,
   output logic [CNT_W-1:0] cnt,
   output logic [RD_W-1:0]  lo_half,
   output logic [RD_W-1:0]  hi_frozen
);
   localparam int HI_W = CNT_W - RD_W;

   logic [RD_W-1:0] hi_ext;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (inc && !(&cnt))
               cnt <= cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (inc)
               cnt <= cnt + 1'b1;
         end
      end

      if (HI_W == RD_W) begin : g_hi_full
         assign hi_ext = cnt[CNT_W-1:RD_W];
      end else begin : g_hi_pad
         assign hi_ext = {{(RD_W-HI_W){1'b0}}, cnt[CNT_W-1:RD_W]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_frozen <= '0;
      else if (rd_lo)
         hi_frozen <= hi_ext;
   end

   assign lo_half = cnt[RD_W-1:0];
endmodule

// File: rtl/trig_busy_gen.sv
`timescale 1ns/1ps
module trig_busy_gen
   import tbg_pkg::*;
#(
   parameter int             TICK_CYCLES = 400,
   parameter int             TMO_W       = 16,
   parameter logic [TMO_W-1:0] TMO_RESET = 'h000A,
   parameter int             CNT_W       = 32,
   parameter int             RD_W        = 16,
   parameter bit             SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l0_trig,
   input  logic              buf_full,
   input  logic              rx_ready,
   input  logic              tmo_we,
   input  logic [TMO_W-1:0]  tmo_wdata,
   output logic [TMO_W-1:0]  tmo_value,
   input  logic              cnt_rd_lo,
   output logic              busy_out,
   output logic [COND_W-1:0] busy_cond,
   output logic [RD_W-1:0]   busy_time_lo,
   output logic [RD_W-1:0]   busy_time_hi
);
   generate
      if (TICK_CYCLES < 1) begin : g_bad_tick
         $error("TICK_CYCLES must be at least 1");
      end
      if (CNT_W <= RD_W || CNT_W > 2 * RD_W) begin : g_bad_cnt
         $error("CNT_W must lie in (RD_W, 2*RD_W]");
      end
      if (TMO_W < 1) begin : g_bad_tmo
         $error("TMO_W must be positive");
      end
   endgenerate

   logic [TMO_W-1:0] tmo_reg;
   logic             timer_active;
   logic [CNT_W-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tmo_reg <= TMO_RESET;
      else if (tmo_we)
         tmo_reg <= tmo_wdata;
   end
   assign tmo_value = tmo_reg;

   tbg_tick_timer #(
      .TICK_CYCLES (TICK_CYCLES),
      .TMO_W       (TMO_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (l0_trig),
      .load_val (tmo_reg),
      .active   (timer_active)
   );

   tbg_busy_cond u_cond (
      .timer_active (timer_active),
      .buf_full     (buf_full),
      .rx_ready     (rx_ready),
      .busy         (busy_out),
      .cond         (busy_cond)
   );

   tbg_busy_meter #(
      .CNT_W    (CNT_W),
      .RD_W     (RD_W),
      .SATURATE (SATURATE)
   ) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (busy_out),
      .rd_lo     (cnt_rd_lo),
      .cnt       (busy_cnt),
      .lo_half   (busy_time_lo),
      .hi_frozen (busy_time_hi)
   );
endmodule

// File: rtl/tbg_checker.sv
`timescale 1ns/1ps
module tbg_checker #(
   parameter int TMO_W    = 16,
   parameter int CNT_W    = 32,
   parameter int RD_W     = 16,
   parameter bit SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             l0_trig,
   input logic             buf_full,
   input logic             rx_ready,
   input logic [TMO_W-1:0] tmo_value,
   input logic             cnt_rd_lo,
   input logic             busy_out,
   input logic [15:0]      busy_cond,
   input logic [CNT_W-1:0] busy_cnt,
   input logic [RD_W-1:0]  busy_time_hi
);
   localparam int HI_W = CNT_W - RD_W;

   // R2
   l0_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_trig && tmo_value != '0) |=> (busy_cond[0] && busy_out));

   // R4
   zero_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_trig && tmo_value == '0) |=> !busy_cond[0]);

   // R5
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> (busy_out && busy_cond[1]));

   // R6
   not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready |-> (busy_out && busy_cond[15]));

   // R7
   idle_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_out |-> (busy_cond == 16'h0000));

   // R8
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_out |=> $stable(busy_cnt));

   // R8
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_out && !(&busy_cnt)) |=> (busy_cnt == CNT_W'($past(busy_cnt) + 1'b1)));

   generate
      if (SATURATE) begin : g_sat_chk
         // R9
         sat_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (&busy_cnt) |=> (&busy_cnt));
      end
   endgenerate

   // R10
   hi_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rd_lo |=> (busy_time_hi[HI_W-1:0] == $past(busy_cnt[CNT_W-1:RD_W])));

   // R10
   hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_rd_lo |=> $stable(busy_time_hi));
endmodule

bind trig_busy_gen tbg_checker #(
   .TMO_W    (TMO_W),
   .CNT_W    (CNT_W),
   .RD_W     (RD_W),
   .SATURATE (SATURATE)
) u_tbg_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .l0_trig      (l0_trig),
   .buf_full     (buf_full),
   .rx_ready     (rx_ready),
   .tmo_value    (tmo_value),
   .cnt_rd_lo    (cnt_rd_lo),
   .busy_out     (busy_out),
   .busy_cond    (busy_cond),
   .busy_cnt     (busy_cnt),
   .busy_time_hi (busy_time_hi)
);

// File: tb/trig_busy_gen_test.sv
`timescale 1ns/1ps
module trig_busy_gen_test;
   localparam int TICK = 400;
   localparam int TW   = 16;
   localparam int CW   = 12;
   localparam int RW   = 8;
   localparam int MAXC = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          l0 = 1'b0;
   logic          full = 1'b0;
   logic          rdy = 1'b1;
   logic          we = 1'b0;
   logic [TW-1:0] wd = '0;
   logic          rd = 1'b0;
   logic [TW-1:0] tmo_value;
   logic          busy_out;
   logic [15:0]   busy_cond;
   logic [RW-1:0] busy_time_lo;
   logic [RW-1:0] busy_time_hi;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // behavioural reference state
   int rem_m  = 0;
   int tmo_m  = 10;
   int cnt_m  = 0;
   int snap_m = 0;

   always #2 clk = ~clk;

   trig_busy_gen #(
      .TICK_CYCLES (TICK),
      .TMO_W       (TW),
      .TMO_RESET   (16'h000A),
      .CNT_W       (CW),
      .RD_W        (RW),
      .SATURATE    (1'b1)
   ) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .l0_trig      (l0),
      .buf_full     (full),
      .rx_ready     (rdy),
      .tmo_we       (we),
      .tmo_wdata    (wd),
      .tmo_value    (tmo_value),
      .cnt_rd_lo    (rd),
      .busy_out     (busy_out),
      .busy_cond    (busy_cond),
      .busy_time_lo (busy_time_lo),
      .busy_time_hi (busy_time_hi)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit model_busy();
      return (rem_m > 0) || full || !rdy;
   endfunction

   task automatic compare_all();
      chk("R2", "busy_out", busy_out, model_busy());
      chk("R7", "busy_cond", busy_cond, {!rdy, 13'b0, full, (rem_m > 0)});
      chk("R8", "busy_time_lo", busy_time_lo, cnt_m & ((1 << RW) - 1));
      chk("R10", "busy_time_hi", busy_time_hi, snap_m);
      chk("R11", "tmo_value", tmo_value, tmo_m);
   endtask

   task automatic step();
      bit b;
      @(posedge clk);
      b = model_busy();
      if (rd) snap_m = cnt_m >> RW;
      if (b && cnt_m < MAXC) cnt_m++;
      if (l0) rem_m = tmo_m * TICK;
      else if (rem_m > 0) rem_m--;
      if (we) tmo_m = int'(wd);
      @(negedge clk);
      compare_all();
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic pulse_l0();
      l0 = 1'b1; step(); l0 = 1'b0;
   endtask

   task automatic write_tmo(input int v);
      we = 1'b1; wd = TW'(v); step(); we = 1'b0;
   endtask

   initial begin
      int busy_len;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "tmo_value", tmo_value, 16'h000A);
      chk("R1", "busy_time_lo", busy_time_lo, 0);
      chk("R1", "busy_time_hi", busy_time_hi, 0);
      chk("R1", "busy_out", busy_out, 0);
      chk("R1", "busy_cond", busy_cond, 0);

      // R2 isolated trigger, default dwell of 10 ticks
      pulse_l0();
      busy_len = busy_out ? 1 : 0;
      for (int i = 0; i < 4010; i++) begin
         step();
         if (busy_out) busy_len++;
      end
      chk("R2", "busy length", busy_len, 10 * TICK);

      // R11 write dwell = 2 ticks
      write_tmo(2);
      chk("R11", "tmo_value after write", tmo_value, 2);

      // R3 retrigger mid-dwell
      pulse_l0();
      steps(499);
      pulse_l0();
      steps(750);
      chk("R3", "busy after restart", busy_out, 1);
      steps(60);
      chk("R3", "busy after restarted dwell", busy_out, 0);

      // R11 write and trigger at the same edge: old value (2) used
      we = 1'b1; wd = 16'd0; l0 = 1'b1; step(); we = 1'b0; l0 = 1'b0;
      chk("R11", "timer started with prior value", busy_cond[0], 1);
      steps(2 * TICK + 5);

      // R4 zero dwell
      pulse_l0();
      chk("R4", "timer flag with zero dwell", busy_cond[0], 0);
      chk("R4", "busy with zero dwell", busy_out, 0);

      // R5 buffer full beyond timer expiry
      write_tmo(1);
      pulse_l0();
      steps(100);
      full = 1'b1;
      steps(500);
      chk("R5", "busy held while full", busy_out, 1);
      chk("R5", "cond while full only", busy_cond, 16'h0002);
      full = 1'b0;
      step();
      chk("R5", "busy after full drops", busy_out, 0);

      // R6 receiver not ready
      rdy = 1'b0;
      step();
      chk("R6", "cond not ready", busy_cond, 16'h8000);
      chk("R6", "busy not ready", busy_out, 1);

      // R10 frozen high half across reads
      steps(10);
      rd = 1'b1; step(); rd = 1'b0;
      chk("R10", "hi frozen", busy_time_hi, snap_m);
      chk("R8", "lo live", busy_time_lo, cnt_m & 8'hFF);
      steps(300);
      chk("R10", "hi kept between reads", busy_time_hi, snap_m);

      // R9 saturation
      steps(4200);
      rd = 1'b1; step(); rd = 1'b0;
      chk("R9", "lo saturated", busy_time_lo, 8'hFF);
      chk("R9", "hi saturated", busy_time_hi, 8'h0F);
      rdy = 1'b1;
      steps(5);
      chk("R8", "lo holds when idle", busy_time_lo, 8'hFF);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule